// File: doc/BRIEF.md
# PHY Force-Mode Management Configurator

This block brings up a row of attached Ethernet PHYs once, right after the chip leaves reset. It takes a set of per-port strap inputs shortly after reset is released. These are a force-mode enable, a forced speed and a forced duplex, plus a base PHY address. It then acts as a clause-22 MDIO master and writes the basic control register (register 0) of each PHY in turn.

A port whose force enable is set gets a control word that selects the strapped speed and duplex and turns auto-negotiation off. A port without force enable gets a control word that turns auto-negotiation on and restarts it.

The management clock is a fixed division of the system clock. Each frame is a plain write frame. After the last PHY has been written, the block raises a done flag and leaves the MDIO line idle from then on. Strap values that change after they have been captured have no effect.

Top module: `phy_strap_cfg`

## Requirements
- R1: While `rst_n` is low, `mdc`, `mdio_oe` and `done` are all low.
- R2: `mdc` is periodic with a period of exactly CLK_DIV system clocks. It is low for CLK_DIV/2 clocks and high for CLK_DIV/2 clocks.
- R3: `mdio_o` and `mdio_oe` change only in the clock cycle in which `mdc` falls, so they are stable at every rising edge of `mdc`.
- R4: The straps and `phy_addr_base` are captured on the third rising clock edge after `rst_n` goes high. Any later change to them has no effect on the frames sent.
- R5: The first rise of `mdio_oe` comes no sooner than START_DLY clocks after `rst_n` goes high, and no later than START_DLY + CLK_DIV + 8 clocks after it.
- R6: Each frame keeps `mdio_oe` high for exactly 64 `mdc` periods. Sampled at the rising edges of `mdc`, MSB first, the frame carries the following fields in order:
  - 32 ones
  - start bits 01
  - opcode 01
  - the 5-bit PHY address
  - the 5-bit register address 00000
  - turnaround bits 10
  - 16 data bits
- R7: For a port with force enable set, the data word has bit 13 equal to the speed strap and bit 8 equal to the duplex strap. Bit 12 is 0, and all other bits are 0.
- R8: For a port with force enable clear, the data word is 0x1200 (bits 12 and 9 set). That port's speed and duplex straps have no effect on it.
- R9: Exactly one frame is sent per port, in ascending port order. Port i is written at PHY address (base + i) mod 32.
- R10: Consecutive frames are separated by at least one rising edge of `mdc` during which `mdio_oe` is low.
- R11: `done` rises only after the last frame has ended. It then stays high until reset, and `mdio_oe` stays low while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_force_en | input | NUM_PORTS | Per-port force-mode enable strap |
| strap_speed | input | NUM_PORTS | Per-port forced speed strap (1 = 100 Mb/s) |
| strap_duplex | input | NUM_PORTS | Per-port forced duplex strap (1 = full) |
| phy_addr_base | input | 5 | PHY address of port 0 |
| mdc | output | 1 | Management clock, system clock / CLK_DIV |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| done | output | 1 | All PHYs written |

## Verification
Any wrong internal state shows up on the MDIO frames themselves, which the bench decodes at the rising edges of `mdc`:

- A miscount in the bit counter changes the frame length within the frame that suffers it.
- A wrong port index or stale strap capture produces a wrong PHY address or data word in that frame.
- A bad control-word mapping flips bit 13, 12, 9 or 8 on the very first affected port.

Sequencing faults show up by the end of the run:

- A broken delay counter moves the first `mdio_oe` rise out of its window.
- A broken order or done condition shows as a frame count or done timing that differs from the port count.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;

  localparam int PRE_W   = 32;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 16;
  localparam int FRAME_W = PRE_W + 2 + 2 + ADDR_W + ADDR_W + 2 + DATA_W;

  localparam logic [ADDR_W-1:0] CTRL_REG = '0;

  localparam int BIT_SPEED  = 13;
  localparam int BIT_ANEN   = 12;
  localparam int BIT_ANRST  = 9;
  localparam int BIT_DUPLEX = 8;

  typedef enum logic [2:0] {
    SQ_LATCH,
    SQ_WAIT,
    SQ_ISSUE,
    SQ_BUSY,
    SQ_DONE
  } seq_state_e;

  // control word for one port
  function automatic logic [DATA_W-1:0] ctrl_word(input logic fm,
                                                  input logic spd,
                                                  input logic dpx);
    logic [DATA_W-1:0] w;
    w = '0;
    if (fm) begin
      w[BIT_SPEED]  = spd;
      w[BIT_DUPLEX] = dpx;
      w[BIT_ANEN]   = 1'b0;
    end else begin
      w[BIT_ANEN]  = 1'b1;
      w[BIT_ANRST] = 1'b1;
    end
    return w;
  endfunction

  // complete clause-22 write frame, MSB goes out first
  function automatic logic [FRAME_W-1:0] wr_frame(input logic [ADDR_W-1:0] phy,
                                                  input logic [ADDR_W-1:0] ra,
                                                  input logic [DATA_W-1:0] d);
    return {{PRE_W{1'b1}}, 2'b01, 2'b01, phy, ra, 2'b10, d};
  endfunction

endpackage

// File: rtl/phy_rst_sync.sv
module phy_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/phy_mdc_gen.sv
module phy_mdc_gen #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic tick_fall
);

  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + CW'(1);
    mdc_d = mdc_q;
    if (cnt_q == CW'(HALF - 1)) mdc_d = 1'b1;
    else if (wrap)              mdc_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign tick_fall = wrap;

endmodule

// File: rtl/phy_mdio_shifter.sv
module phy_mdio_shifter
  import phy_cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_fall_i,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               fin_o
);

  localparam int CNT_W = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               act_q, act_d;
  logic               pend_q, pend_d;
  logic               fin_q, fin_d;
  logic               load_en;

  assign load_en = start_i && !pend_q && !act_q;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    act_d  = act_q;
    pend_d = pend_q;
    fin_d  = 1'b0;
    if (load_en) begin
      sh_d   = frame_i;
      pend_d = 1'b1;
    end
    if (tick_fall_i) begin
      if (act_q) begin
        if (cnt_q == '0) begin
          act_d = 1'b0;
          fin_d = 1'b1;
        end else begin
          sh_d  = {sh_q[FRAME_W-2:0], 1'b0};
          cnt_d = cnt_q - CNT_W'(1);
        end
      end else if (pend_q) begin
        act_d  = 1'b1;
        pend_d = 1'b0;
        cnt_d  = CNT_W'(FRAME_W - 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      act_q  <= act_d;
      pend_q <= pend_d;
      fin_q  <= fin_d;
    end
  end

  assign mdio_o  = act_q & sh_q[FRAME_W-1];
  assign mdio_oe = act_q;
  assign fin_o   = fin_q;

endmodule

// File: rtl/phy_cfg_sequencer.sv
module phy_cfg_sequencer
  import phy_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int START_DLY = 500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] strap_force_en,
  input  logic [NUM_PORTS-1:0] strap_speed,
  input  logic [NUM_PORTS-1:0] strap_duplex,
  input  logic [ADDR_W-1:0]    phy_addr_base,
  input  logic                 fin_i,
  output logic                 start_o,
  output logic [FRAME_W-1:0]   frame_o,
  output logic                 done_o
);

  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int DW    = $clog2(START_DLY + 1);

  seq_state_e st_q, st_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [DW-1:0]        dly_q, dly_d;
  logic                 cap_en;

  logic [NUM_PORTS-1:0] fm_q, spd_q, dpx_q;
  logic [ADDR_W-1:0]    base_q;
  logic [DATA_W-1:0]    word_w [NUM_PORTS];

  // one control word per port
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_word
    assign word_w[p] = ctrl_word(fm_q[p], spd_q[p], dpx_q[p]);
  end

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    dly_d   = dly_q;
    cap_en  = 1'b0;
    start_o = 1'b0;
    case (st_q)
      SQ_LATCH: begin
        cap_en = 1'b1;
        dly_d  = '0;
        st_d   = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (dly_q == DW'(START_DLY - 1)) st_d = SQ_ISSUE;
        else                             dly_d = dly_q + DW'(1);
      end
      SQ_ISSUE: begin
        start_o = 1'b1;
        st_d    = SQ_BUSY;
      end
      SQ_BUSY: begin
        if (fin_i) begin
          if (idx_q == IDX_W'(NUM_PORTS - 1)) begin
            st_d = SQ_DONE;
          end else begin
            idx_d = idx_q + IDX_W'(1);
            st_d  = SQ_ISSUE;
          end
        end
      end
      SQ_DONE: st_d = SQ_DONE;
      default: st_d = SQ_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_LATCH;
      idx_q <= '0;
      dly_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      dly_q <= dly_d;
    end
  end

  // strap capture, enabled once after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fm_q   <= '0;
      spd_q  <= '0;
      dpx_q  <= '0;
      base_q <= '0;
    end else if (cap_en) begin
      fm_q   <= strap_force_en;
      spd_q  <= strap_speed;
      dpx_q  <= strap_duplex;
      base_q <= phy_addr_base;
    end
  end

  assign frame_o = wr_frame(base_q + ADDR_W'(idx_q), CTRL_REG, word_w[idx_q]);
  assign done_o  = (st_q == SQ_DONE);

endmodule

// File: rtl/phy_strap_cfg.sv
module phy_strap_cfg
  import phy_cfg_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CLK_DIV   = 32,
  parameter int START_DLY = 500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] strap_force_en,
  input  logic [NUM_PORTS-1:0] strap_speed,
  input  logic [NUM_PORTS-1:0] strap_duplex,
  input  logic [ADDR_W-1:0]    phy_addr_base,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done
);

  logic               rst_n_int;
  logic               tick_fall;
  logic               start;
  logic               fin;
  logic [FRAME_W-1:0] frame;

  phy_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  phy_mdc_gen #(.DIV(CLK_DIV)) u_mdc (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .mdc       (mdc),
    .tick_fall (tick_fall)
  );

  phy_cfg_sequencer #(
    .NUM_PORTS (NUM_PORTS),
    .START_DLY (START_DLY)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .strap_force_en (strap_force_en),
    .strap_speed    (strap_speed),
    .strap_duplex   (strap_duplex),
    .phy_addr_base  (phy_addr_base),
    .fin_i          (fin),
    .start_o        (start),
    .frame_o        (frame),
    .done_o         (done)
  );

  phy_mdio_shifter u_shf (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .tick_fall_i (tick_fall),
    .start_i     (start),
    .frame_i     (frame),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .fin_o       (fin)
  );

endmodule

// File: rtl/phy_strap_cfg_chk.sv
module phy_strap_cfg_chk #(
  parameter int CLK_DIV = 32,
  parameter int FRAME_W = 64
) (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic done
);

  localparam int RW = $clog2(CLK_DIV) + 2;
  localparam int BW = $clog2(FRAME_W) + 2;

  logic          mdc_d;
  logic          seen_q;
  logic [RW-1:0] run_q;
  logic [BW-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_d  <= 1'b0;
      seen_q <= 1'b0;
      run_q  <= '0;
      bits_q <= '0;
    end else begin
      mdc_d <= mdc;
      if (mdc != mdc_d) begin
        run_q  <= RW'(1);
        seen_q <= 1'b1;
      end else if (run_q != '1) begin
        run_q <= run_q + RW'(1);
      end
      if (!mdio_oe)             bits_q <= '0;
      else if (mdc && !mdc_d)   bits_q <= bits_q + BW'(1);
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!mdc && !mdio_oe && !done));

  assert_mdc_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((mdc != mdc_d) && seen_q) |-> (run_q == RW'(CLK_DIV / 2)));

  assert_oe_at_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $fell(mdc));

  assert_data_at_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

  assert_frame_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdio_oe) |-> (bits_q == BW'(FRAME_W)));

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  assert_quiet_after_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mdio_oe);

endmodule

bind phy_strap_cfg phy_strap_cfg_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe),
  .done    (done)
);

// File: tb/sim_phy_strap_cfg.sv
`timescale 1ns/1ps
module sim_phy_strap_cfg;

  localparam int CLK_PERIOD = 10;
  localparam int NP         = 4;
  localparam int DIV        = 32;
  localparam int DLY        = 500;
  localparam int HALF       = DIV / 2;
  localparam int WATCHDOG   = 190000;
  localparam int RUN_LIMIT  = 20000;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] s_force, s_speed, s_duplex;
  logic [4:0]    s_base;
  logic          mdc, mdio_o, mdio_oe, done;

  phy_strap_cfg #(
    .NUM_PORTS (NP),
    .CLK_DIV   (DIV),
    .START_DLY (DLY)
  ) u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .strap_force_en (s_force),
    .strap_speed    (s_speed),
    .strap_duplex   (s_duplex),
    .phy_addr_base  (s_base),
    .mdc            (mdc),
    .mdio_o         (mdio_o),
    .mdio_oe        (mdio_oe),
    .done           (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  // monitor state
  logic [63:0] frames [NP+2];
  int          lens   [NP+2];
  int          nfr, nbits, since_rel, last_rise, first_oe, idle_rises;
  int          per_bad, nper, r3_bad, gap_bad, post_done_bad, done_frames;
  logic [63:0] sh;
  logic        mdc_p, oe_p, o_p, done_p;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      nfr = 0; nbits = 0; since_rel = 0; last_rise = -1; first_oe = -1;
      idle_rises = 0; per_bad = 0; nper = 0; r3_bad = 0; gap_bad = 0;
      post_done_bad = 0; done_frames = -1; sh = '0;
      mdc_p = mdc; oe_p = mdio_oe; o_p = mdio_o; done_p = done;
    end else begin
      since_rel++;
      if (mdc && !mdc_p) begin
        if (last_rise >= 0) begin
          nper++;
          if (since_rel - last_rise != DIV) per_bad++;
        end
        last_rise = since_rel;
        if (mdio_oe) begin
          sh = {sh[62:0], mdio_o};
          nbits++;
        end else begin
          idle_rises++;
        end
      end
      if (!mdc && mdc_p && last_rise >= 0 && (since_rel - last_rise != HALF)) per_bad++;
      if (mdio_oe && !oe_p) begin
        if (first_oe < 0) first_oe = since_rel;
        if (nfr > 0 && idle_rises < 1) gap_bad++;
        nbits = 0;
      end
      if (!mdio_oe && oe_p) begin
        if (nfr < NP + 2) begin
          frames[nfr] = sh;
          lens[nfr]   = nbits;
        end
        nfr++;
        idle_rises = 0;
      end
      if (((mdio_oe != oe_p) || (mdio_o != o_p)) && !(mdc_p && !mdc)) r3_bad++;
      if (done && !done_p) done_frames = nfr;
      if (done && mdio_oe) post_done_bad++;
      mdc_p = mdc; oe_p = mdio_oe; o_p = mdio_o; done_p = done;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic fm, input logic sp, input logic dp);
    logic [15:0] w;
    w = '0;
    if (fm) begin
      w[13] = sp;
      w[8]  = dp;
    end else begin
      w[12] = 1'b1;
      w[9]  = 1'b1;
    end
    return w;
  endfunction

  function automatic logic [63:0] exp_frame(input logic [4:0] a, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, a, 5'b00000, 2'b10, d};
  endfunction

  task automatic run_case(input logic [NP-1:0] f, input logic [NP-1:0] sp,
                          input logic [NP-1:0] dp, input logic [4:0] b);
    int t;
    bit all_ok;
    logic [63:0] ef;
    logic [4:0]  pa;
    @(negedge clk); #1;
    rst_n = 1'b0;
    s_force = f; s_speed = sp; s_duplex = dp; s_base = b;
    repeat (4) @(negedge clk);
    chk(!mdc && !mdio_oe && !done, "R1", "outputs in reset",
        {61'd0, mdc, mdio_oe, done}, 64'd0);
    #1 rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    s_force = ~f; s_speed = ~sp; s_duplex = ~dp; s_base = b ^ 5'h15;
    t = 0;
    while (!done && t < RUN_LIMIT) begin
      @(negedge clk);
      t++;
    end
    repeat (3 * DIV) @(negedge clk);

    chk(nfr == NP, "R9", "frame count", 64'(nfr), 64'(NP));
    all_ok = 1'b1;
    for (int i = 0; i < NP && i < nfr; i++) begin
      pa = b + 5'(i);
      ef = exp_frame(pa, exp_word(f[i], sp[i], dp[i]));
      chk(lens[i] == 64, "R6", $sformatf("frame %0d length", i), 64'(lens[i]), 64'd64);
      chk(frames[i][63:16] == ef[63:16], "R9", $sformatf("frame %0d header/address", i),
          frames[i], ef);
      if (f[i])
        chk(frames[i][15:0] == ef[15:0], "R7", $sformatf("port %0d forced word", i),
            64'(frames[i][15:0]), 64'(ef[15:0]));
      else
        chk(frames[i][15:0] == ef[15:0], "R8", $sformatf("port %0d autoneg word", i),
            64'(frames[i][15:0]), 64'(ef[15:0]));
      if (frames[i] != ef) all_ok = 1'b0;
    end
    chk(all_ok && nfr == NP, "R4", "frames follow straps held at capture",
        64'(all_ok), 64'd1);
    chk(first_oe >= DLY && first_oe <= DLY + DIV + 8, "R5", "first mdio_oe rise",
        64'(first_oe), 64'(DLY));
    chk(per_bad == 0 && nper > 0, "R2", "mdc period/high time faults",
        64'(per_bad), 64'd0);
    chk(r3_bad == 0, "R3", "mdio changes off mdc fall", 64'(r3_bad), 64'd0);
    chk(gap_bad == 0, "R10", "idle gap between frames", 64'(gap_bad), 64'd0);
    chk(done && done_frames == NP && post_done_bad == 0, "R11",
        "done after last frame, quiet after",
        64'(done_frames), 64'(NP));
  endtask

  initial begin
    int unsigned seed_v;
    rst_n = 1'b0;
    s_force = '0; s_speed = '0; s_duplex = '0; s_base = '0;
    seed_v = $urandom(32'd20240611);
    // directed corners
    run_case(4'b1111, 4'b1010, 4'b0110, 5'd0);   // all forced
    run_case(4'b0000, 4'b1111, 4'b1111, 5'd7);   // none forced, straps ignored
    run_case(4'b0101, 4'b0011, 4'b1001, 5'd30);  // mixed, address wraps
    run_case(4'b1111, 4'b0000, 4'b0000, 5'd31);  // forced 10M half, wrap at once
    // random
    for (int k = 0; k < 4; k++) begin
      run_case(4'($urandom), 4'($urandom), 4'($urandom), 5'($urandom));
    end
    summary();
    $finish;
  end

endmodule